// File: doc/BRIEF.md
# Dual Wiper Register I2C Controller

This block is an I2C target that sets the positions of two 256-step digital potentiometer wipers. Each channel owns a volatile wiper register, whose value is sent out directly as an 8-bit tap code, and a persistent start-up register. The host can read and write all four registers over the bus. When reset is asserted, each wiper register takes its channel's persistent value, so the wipers come up at their stored positions before the bus is served.

The bus side detects start and stop conditions on oversampled SCL and SDA. It compares the address byte with a fixed upper nibble followed by three strap pins, and handles a pointer byte and any number of data bytes. A write to a persistent register starts a fixed busy window. While that window runs the device does not answer its address, so the host can poll until the write is done. An active-low protect input blocks every register update but still lets reads through. Persistent storage is modelled as flip-flops that are not reset, together with a program delay.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: The 7-bit target address is {4'b0101, strap[2:0]}, with the R/W bit as the LSB of the address byte (0 = write). A matching address is acknowledged by pulling SDA low (sda_oe = 1) during the ninth clock. A mismatch in any address bit gets no acknowledge, and the rest of the frame is ignored.
- R2: The byte after an acknowledged write address sets the register pointer from its bits [1:0]. Code 0 selects wiper 0, 1 selects wiper 1, 2 selects persistent value 0 and 3 selects persistent value 1.
- R3: A data byte written to pointer 0 or 1 appears on tap0 or tap1 respectively by the end of that byte's acknowledge clock. Tap code 0 is the low end of the ladder and 255 is the high end.
- R4: A read frame returns the register at the current pointer, MSB first. Persistent registers read back the last value they committed.
- R5: The pointer advances by one after every data byte, on both reads and writes, and wraps from 3 to 0.
- R6: While wp_n is low, the address and pointer bytes are still acknowledged and the pointer still moves. Data bytes are acknowledged but change no register, and reads work normally.
- R7: A data byte written to pointer 2 or 3 starts a busy window of NV_BUSY_CYC clocks, and a further such write restarts it. The value is committed at the end of the window. During the window the address is not acknowledged.
- R8: While rst_n is low, each wiper register loads its channel's persistent value. Persistent values survive the reset, and SDA is released.
- R9: A stop condition returns the controller to idle and releases SDA. A start condition in the middle of a byte abandons that byte without any register update.
- R10: A host NACK after a read byte ends the transfer. SDA then stays released until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL by at least 8x |
| rst_n | input | 1 | Synchronous active-low reset (power-up recall) |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap | input | 3 | Address strap pins, low three address bits |
| wp_n | input | 1 | Active-low write protect |
| tap0 | output | 8 | Tap code of wiper 0 |
| tap1 | output | 8 | Tap code of wiper 1 |

## Verification
The bench sweeps all 128 addresses for one strap setting and tests every strap value against its own address and a neighbour. A decoder that dropped or swapped a strap bit would acknowledge the wrong frames. It writes the persistent registers and then polls straight away: a busy timer that was missing or too short would answer the poll, and a commit at the wrong time would read back stale data after the window. Pointer wrap is tested in both directions, because a pointer that saturates or skips would read or write the wrong register. Write protect, an aborted byte and a host NACK are each checked at the taps or on the released SDA line. A design that leaked a write or kept driving the bus would show a changed tap or a low bit on the line.

// File: rtl/dpot_pkg.sv
// Shared types for the dual wiper controller.
// Assumes a 2-bit register pointer: bit 1 picks the register kind, bit 0 the channel.
package dpot_pkg;
    localparam int REG_AW = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } byte_phase_e;
endpackage

// File: rtl/dpot_bus_sync.sv
// Brings SCL and SDA into the clock domain and produces one-cycle events for
// SCL edges, start and stop. Assumes STAGES >= 2 and that each SCL level lasts
// for several clocks.
module dpot_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_bit,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_now;
    logic              sda_now;

    // Synchronizer chains plus one history stage; the bus idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        scl_now   = scl_pipe[STAGES-1];
        sda_now   = sda_pipe[STAGES-1];
        scl_rise  = scl_now & ~scl_d;
        scl_fall  = ~scl_now & scl_d;
        sda_bit   = sda_now;
        start_det = scl_now & scl_d & sda_d & ~sda_now;
        stop_det  = scl_now & scl_d & ~sda_d & sda_now;
    end
endmodule

// File: rtl/dpot_regfile.sv
// Holds the wiper and persistent registers of each channel, the program-delay
// timer and the read mux. The persistent array has no reset, so it keeps its
// value across rst_n; the wipers reload from it while rst_n is low.
// Assumes wr_en already includes the write-protect gating.
module dpot_regfile
    import dpot_pkg::*;
#(
    parameter int DW          = 8,
    parameter int NV_BUSY_CYC = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [REG_AW-1:0]    rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic [2**(REG_AW-1)*DW-1:0] taps,
    output logic                 nv_busy
);
    localparam int CW  = REG_AW - 1;
    localparam int NCH = 2 ** CW;
    localparam int BCW = $clog2(NV_BUSY_CYC + 1);

    logic [BCW-1:0]    busy_cnt;
    logic              iv_wr;
    logic              commit;
    logic [NCH*DW-1:0] nv_bus;

    assign iv_wr   = wr_en & wr_addr[REG_AW-1];
    assign commit  = (busy_cnt == BCW'(1)) & ~iv_wr;
    assign nv_busy = (busy_cnt != '0);

    // Program-delay timer: reloads on each persistent write, counts to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (iv_wr) begin
            busy_cnt <= BCW'(NV_BUSY_CYC);
        end else if (busy_cnt != '0) begin
            busy_cnt <= busy_cnt - BCW'(1);
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [DW-1:0] wiper_q;
        logic [DW-1:0] nv_q;
        logic [DW-1:0] pend_q;
        logic          pend_v;
        logic          sel;

        assign sel = (wr_addr[CW-1:0] == CW'(g));

        // Live wiper: recall from persistent copy in reset, else bus write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wiper_q <= nv_q;
            end else if (wr_en && !wr_addr[REG_AW-1] && sel) begin
                wiper_q <= wr_data;
            end
        end

        // Pending persistent value waiting for the program delay to end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_v <= 1'b0;
                pend_q <= '0;
            end else if (iv_wr && sel) begin
                pend_v <= 1'b1;
                pend_q <= wr_data;
            end else if (commit) begin
                pend_v <= 1'b0;
            end
        end

        // Persistent cell model: no reset so the contents survive rst_n.
        always_ff @(posedge clk) begin
            if (commit && pend_v) begin
                nv_q <= pend_q;
            end
        end

        assign taps[g*DW +: DW]   = wiper_q;
        assign nv_bus[g*DW +: DW] = nv_q;

        AST_RESET_RECALL: assert property (@(posedge clk)
            $rose(rst_n) |-> (wiper_q == nv_q)) else $error("recall"); // R8
    end

    // Read mux by register kind and channel.
    always_comb begin
        if (rd_addr[REG_AW-1]) begin
            rd_data = nv_bus[rd_addr[CW-1:0]*DW +: DW];
        end else begin
            rd_data = taps[rd_addr[CW-1:0]*DW +: DW];
        end
    end

    AST_IV_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        iv_wr |=> nv_busy) else $error("busy start"); // R7
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BCW'(NV_BUSY_CYC)) else $error("busy bound"); // R7
endmodule

// File: rtl/dpot_i2c_fsm.sv
// Byte-level I2C target: address match, pointer byte, data writes and read
// streaming with auto-increment. Drives SDA only by pulling it low.
// Assumes the edge and condition events come from dpot_bus_sync.
module dpot_i2c_fsm
    import dpot_pkg::*;
#(
    parameter int         DW      = 8,
    parameter logic [3:0] ADDR_HI = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_bit,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap,
    input  logic              wp_n,
    input  logic              nv_busy,
    input  logic [DW-1:0]     rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_waddr,
    output logic [DW-1:0]     reg_wdata,
    output logic              sda_oe
);
    localparam int BITW = $clog2(DW + 1);

    bus_state_e       state;
    byte_phase_e      phase;
    logic [BITW-1:0]  bit_cnt;
    logic [DW-1:0]    rx_sh;
    logic [DW-1:0]    tx_sh;
    logic             rw_q;
    logic             host_ack;
    logic [REG_AW-1:0] ptr;
    logic             addr_hit;

    assign addr_hit = (rx_sh[DW-1:1] == {ADDR_HI, strap});
    assign rd_addr  = ptr;

    // Main protocol sequencer; stop and start override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= PH_ADDR;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_q      <= 1'b0;
            host_ack  <= 1'b0;
            ptr       <= '0;
            reg_we    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
            sda_oe    <= 1'b0;
        end else begin
            reg_we <= 1'b0;
            if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state   <= ST_RX;
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[DW-2:0], sda_bit};
                            bit_cnt <= bit_cnt + BITW'(1);
                        end else if (scl_fall && bit_cnt == BITW'(DW)) begin
                            case (phase)
                                PH_ADDR: begin
                                    if (addr_hit && !nv_busy) begin
                                        rw_q   <= rx_sh[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                PH_PTR: begin
                                    ptr    <= rx_sh[REG_AW-1:0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end
                                default: begin
                                    reg_we    <= wp_n;
                                    reg_waddr <= ptr;
                                    reg_wdata <= rx_sh;
                                    ptr       <= ptr + REG_AW'(1);
                                    sda_oe    <= 1'b1;
                                    state     <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (phase == PH_ADDR && rw_q) begin
                                tx_sh  <= rd_data;
                                sda_oe <= ~rd_data[DW-1];
                                ptr    <= ptr + REG_AW'(1);
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= (phase == PH_ADDR) ? PH_PTR : PH_DATA;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == BITW'(DW - 1)) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx_sh   <= {tx_sh[DW-2:0], 1'b0};
                                sda_oe  <= ~tx_sh[DW-2];
                                bit_cnt <= bit_cnt + BITW'(1);
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_bit;
                        end else if (scl_fall) begin
                            if (host_ack) begin
                                tx_sh   <= rd_data;
                                sda_oe  <= ~rd_data[DW-1];
                                ptr     <= ptr + REG_AW'(1);
                                bit_cnt <= '0;
                                state   <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe) else $error("idle drive"); // R9
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && state == ST_IDLE)) else $error("stop"); // R9
    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX && phase == PH_ADDR && scl_fall && bit_cnt == BITW'(DW) && nv_busy)
        |=> !sda_oe) else $error("busy ack"); // R7
    AST_NO_WRITE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX || state == ST_RACK) |-> !reg_we) else $error("read write"); // R4
endmodule

// File: rtl/dpot_i2c_ctrl.sv
// Top of the dual wiper controller: bus synchronizer, protocol engine and
// register file. Assumes an external open-drain pad: sda_oe = 1 pulls SDA low.
module dpot_i2c_ctrl #(
    parameter int         DW          = 8,
    parameter int         NV_BUSY_CYC = 64,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_HI     = 4'b0101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    input  logic [2:0]    strap,
    input  logic          wp_n,
    output logic [DW-1:0] tap0,
    output logic [DW-1:0] tap1
);
    import dpot_pkg::*;

    logic                scl_rise;
    logic                scl_fall;
    logic                sda_bit;
    logic                start_det;
    logic                stop_det;
    logic                nv_busy;
    logic [DW-1:0]       rd_data;
    logic [REG_AW-1:0]   rd_addr;
    logic                reg_we;
    logic [REG_AW-1:0]   reg_waddr;
    logic [DW-1:0]       reg_wdata;
    logic [2*DW-1:0]     taps;

    dpot_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    dpot_i2c_fsm #(.DW(DW), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_bit),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap),
        .wp_n      (wp_n),
        .nv_busy   (nv_busy),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .sda_oe    (sda_oe)
    );

    dpot_regfile #(.DW(DW), .NV_BUSY_CYC(NV_BUSY_CYC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_addr (reg_waddr),
        .wr_data (reg_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .taps    (taps),
        .nv_busy (nv_busy)
    );

    assign tap0 = taps[0 +: DW];
    assign tap1 = taps[DW +: DW];

    AST_WP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> ($stable(tap0) && $stable(tap1))) else $error("wp leak"); // R6
endmodule

// File: tb/tb_dpot_i2c_ctrl.sv
module tb_dpot_i2c_ctrl;
    localparam int Q    = 5;
    localparam int BUSY = 1500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [2:0] strap = 3'b101;
    logic       wp_n = 1'b1;
    logic [7:0] tap0;
    logic [7:0] tap1;
    int         checks = 0;
    int         errors = 0;

    assign sda_line = sda_h & ~sda_oe;

    always #5 clk = ~clk;

    dpot_i2c_ctrl #(.NV_BUSY_CYC(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
        .sda_oe(sda_oe), .strap(strap), .wp_n(wp_n), .tap0(tap0), .tap1(tap1)
    );

    function automatic logic [6:0] dev_addr();
        return {4'b0101, strap};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; qwait();
        scl_h = 1'b1; qwait();
        sda_h = 1'b0; qwait();
        scl_h = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; qwait();
        scl_h = 1'b1; qwait();
        sda_h = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; qwait();
        scl_h = 1'b1; qwait(); qwait();
        scl_h = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_h = 1'b1; qwait();
        scl_h = 1'b1; qwait();
        b = sda_line; qwait();
        scl_h = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic probe(output logic ack);
        bus_start();
        send_byte({dev_addr(), 1'b0}, ack);
        bus_stop();
    endtask

    task automatic write1(input logic [1:0] p, input logic [7:0] d, output logic ack);
        logic a2;
        bus_start();
        send_byte({dev_addr(), 1'b0}, ack);
        send_byte({6'd0, p}, a2);
        send_byte(d, a2);
        bus_stop();
    endtask

    task automatic write2(input logic [1:0] p, input logic [7:0] d0, input logic [7:0] d1,
                          output logic ack);
        logic a2;
        bus_start();
        send_byte({dev_addr(), 1'b0}, ack);
        send_byte({6'd0, p}, a2);
        send_byte(d0, a2);
        send_byte(d1, a2);
        bus_stop();
    endtask

    task automatic read2(input logic [1:0] p, output logic [7:0] d0, output logic [7:0] d1);
        logic a;
        bus_start();
        send_byte({dev_addr(), 1'b0}, a);
        send_byte({6'd0, p}, a);
        bus_stop();
        bus_start();
        send_byte({dev_addr(), 1'b1}, a);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        bus_stop();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] last0;
        logic [7:0] last1;
        logic       bit_seen;

        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R8 reset releases SDA", sda_oe, 1'b0);

        // R1: every 7-bit address, only {0101,101} answers
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            bus_stop();
            check("R1 address sweep", ack, (7'(a) == 7'b0101101));
        end

        // R1: each strap value matches its own address, not a neighbour
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            probe(ack);
            check("R1 strap own", ack, 1'b1);
            bus_start();
            send_byte({4'b0101, 3'(s) ^ 3'b010, 1'b0}, ack);
            bus_stop();
            check("R1 strap other", ack, 1'b0);
        end
        strap = 3'b101;

        // R2/R3: wiper writes land on the matching tap
        for (int v = 0; v < 16; v++) begin
            last0 = 8'((v * 37 + 11) & 255);
            last1 = ~last0;
            write1(2'd0, last0, ack);
            check("R3 tap0 write", tap0, last0);
            write1(2'd1, last1, ack);
            check("R2 tap1 select", tap1, last1);
        end

        // R4: read back the wipers
        read2(2'd0, d0, d1);
        check("R4 read wiper0", d0, last0);
        check("R4 read wiper1", d1, last1);

        // R7: persistent writes raise busy; address ignored until done
        write2(2'd2, 8'h3C, 8'hC3, ack);
        check("R7 write frame ack", ack, 1'b1);
        check("R7 wiper untouched", tap0, last0);
        probe(ack);
        check("R7 busy nack", ack, 1'b0);
        repeat (BUSY + 50) @(negedge clk);
        probe(ack);
        check("R7 ack after busy", ack, 1'b1);
        read2(2'd2, d0, d1);
        check("R4 read iv0", d0, 8'h3C);
        check("R4 read iv1", d1, 8'hC3);

        // R8: reset recalls persistent values into wipers
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 recall tap0", tap0, 8'h3C);
        check("R8 recall tap1", tap1, 8'hC3);

        // R5: wrap on read 3 -> 0 and on write 3 -> 0
        write1(2'd0, 8'h21, ack);
        read2(2'd3, d0, d1);
        check("R5 read wrap first", d0, 8'hC3);
        check("R5 read wrap second", d1, 8'h21);
        write2(2'd3, 8'h77, 8'h66, ack);
        check("R5 write wrap tap0", tap0, 8'h66);
        repeat (BUSY + 50) @(negedge clk);
        read2(2'd3, d0, d1);
        check("R5 write wrap iv1", d0, 8'h77);

        // R6: protect blocks data, keeps address ack and reads
        wp_n = 1'b0;
        write1(2'd0, 8'hAA, ack);
        check("R6 address ack under protect", ack, 1'b1);
        check("R6 tap0 held", tap0, 8'h66);
        write1(2'd2, 8'hBB, ack);
        probe(ack);
        check("R6 no busy under protect", ack, 1'b1);
        read2(2'd2, d0, d1);
        check("R6 iv0 held", d0, 8'h3C);
        check("R6 iv1 held", d1, 8'h77);
        wp_n = 1'b1;

        // R9: start inside a data byte abandons it
        bus_start();
        send_byte({dev_addr(), 1'b0}, ack);
        send_byte(8'h00, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        bus_stop();
        repeat (4) @(negedge clk);
        check("R9 aborted byte no write", tap0, 8'h66);
        check("R9 SDA released", sda_oe, 1'b0);

        // R10: host NACK ends the read and SDA stays released
        bus_start();
        send_byte({dev_addr(), 1'b0}, ack);
        send_byte(8'h01, ack);
        bus_stop();
        bus_start();
        send_byte({dev_addr(), 1'b1}, ack);
        recv_byte(1'b0, d0);
        check("R10 read value", d0, tap1);
        recv_bit(bit_seen);
        check("R10 line high after nack", bit_seen, 1'b1);
        check("R10 no drive after nack", sda_oe, 1'b0);
        bus_stop();

        summary();
        $finish;
    end
endmodule